// File: doc/BRIEF.md
# JTAG-to-SPI flash bridge

This block lets a debug host reach a serial flash over the boundary-scan chain. It sits behind a user instruction of the TAP and uses only TCK, TDI and TDO while the TAP is in Shift-DR. Toward the chain it looks like a one-bit data register. Toward the flash it drives chip select, a serial clock gated from TCK, and MOSI, and it reads MISO.

A frame on TDI can begin with any number of zeros, which come from bypass registers further up the chain. The first one bit marks the start. The next 32 bits give a cycle count, most significant bit first. Exactly that many SPI clock cycles then follow with chip select low. TDI is forwarded to MOSI on each of those cycles, and the MISO bit sampled on each rising SCLK edge comes back on TDO one TCK cycle later. After that the block ignores further shift cycles, so the returned data can travel through downstream bypass registers. Because the frame finds its own start, no setup is needed for the number or position of other TAPs on the chain.

Top module: `jtag_spi_bridge`

## Requirements
- R1: While hunting in Shift-DR, zero bits on TDI are ignored. CS_N stays high and no SCLK pulse is issued.
- R2: The first one bit on TDI starts a frame. That bit produces no SCLK pulse, and CS_N stays high through it and through the length field.
- R3: The 32 TDI bits after the start bit form the cycle count. The first of these bits is bit 31 and the last is bit 0.
- R4: After the count is loaded, exactly that many SCLK pulses are issued with CS_N low. SCLK is TCK gated, so it rises with TCK. On each rising SCLK edge, MOSI equals the TDI bit of that TCK cycle. The first pulse comes on the TCK cycle right after the last count bit.
- R5: After the counted pulses, CS_N goes high by the next falling TCK edge. All further shift cycles, including one bits, produce no SCLK and no CS_N activity until the block leaves Shift-DR.
- R6: Outside the counted pulses, during Shift-DR, TDO changes on the falling TCK edge to the TDI value captured on the preceding rising edge. This is a one-bit delay path.
- R7: For each counted pulse, the MISO value sampled at its rising edge appears on TDO at the following falling TCK edge.
- R8: A count of zero ends the frame with no CS_N assertion and no SCLK pulse.
- R9: If shift or select drops, CS_N goes high and SCLK stops at once, and the block returns to hunting. If the test-logic-reset input rises, it does the same and also clears TDO. A later frame then works normally.
- R10: When the user instruction is not selected, CS_N stays high and SCLK stays low, whatever TDI carries.
- R11: While test-logic-reset is held, CS_N is 1, SCLK is 0 and TDO is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tlr | input | 1 | High while the TAP is in Test-Logic-Reset (asynchronous reset) |
| sel | input | 1 | High while the bridge's user instruction is loaded |
| shift | input | 1 | High while the TAP is in Shift-DR |
| tdi | input | 1 | Serial data from the chain |
| tdo | output | 1 | Serial data to the chain, updated on falling TCK |
| spi_sclk | output | 1 | Flash clock, TCK gated during counted cycles |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Flash serial input, follows TDI |
| spi_miso | input | 1 | Flash serial output |

## Verification
The assertions assume that sel, shift and tdi change only while TCK is low, as a TAP controller and host adapter produce them. The bench drives every input one nanosecond after a falling edge, so every input is stable before the rising edge. The assertions also assume that MISO changes only on falling SCLK. The bench's flash model steps its pattern on that edge alone. Random frames vary the zero prefix, the count, the drain tail and the payload. Directed frames cover a zero count, aborts by each of the three exit causes, and a deselected frame.

// File: rtl/jtag_spi_bridge.sv
module jtag_spi_bridge #(
  parameter int LEN_W = 32
) (
  input  logic tck,
  input  logic tlr,
  input  logic sel,
  input  logic shift,
  input  logic tdi,
  output logic tdo,
  output logic spi_sclk,
  output logic spi_cs_n,
  output logic spi_mosi,
  input  logic spi_miso
);
  localparam int IDX_W = $clog2(LEN_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(LEN_W - 1);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  typedef enum logic [1:0] {HUNT, LENGTH, XFER, DRAIN} st_t;

  st_t             st;
  logic [LEN_W-1:0] len_sr;
  logic [LEN_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic            en;
  logic            dr;
  logic            tdo_q;

  wire active = sel & shift;
  wire live   = en & active;
  wire [LEN_W-1:0] len_next = {len_sr[LEN_W-2:0], tdi};

  assign spi_cs_n = ~live;
  assign spi_sclk = tck & live;
  assign spi_mosi = tdi;
  assign tdo      = tdo_q;

  always_ff @(posedge tck or posedge tlr) begin
    if (tlr) begin
      st     <= HUNT;
      len_sr <= '0;
      cnt    <= '0;
      idx    <= '0;
    end else if (!active) begin
      st <= HUNT;
    end else begin
      case (st)
        HUNT: if (tdi) begin
          st  <= LENGTH;
          idx <= '0;
        end
        LENGTH: begin
          len_sr <= len_next;
          idx    <= idx + 1'b1;
          if (idx == IDX_LAST) begin
            cnt <= len_next;
            st  <= (len_next == '0) ? DRAIN : XFER;
          end
        end
        XFER: begin
          cnt <= cnt - ONE;
          if (cnt == ONE) st <= DRAIN;
        end
        default: st <= DRAIN;
      endcase
    end
  end

  always_ff @(posedge tck or posedge tlr) begin
    if (tlr)         dr <= 1'b0;
    else if (active) dr <= live ? spi_miso : tdi;
  end

  always_ff @(negedge tck or posedge tlr) begin
    if (tlr) begin
      en    <= 1'b0;
      tdo_q <= 1'b0;
    end else begin
      en    <= active && (st == XFER);
      tdo_q <= dr;
    end
  end

  p_hunt_zero_r1: assert property (@(posedge tck) disable iff (tlr)
    (st == HUNT && active && !tdi) |=> (st == HUNT && spi_cs_n));

  p_marker_r2: assert property (@(posedge tck) disable iff (tlr)
    (st == HUNT && active && tdi) |=> (st == LENGTH && spi_cs_n));

  p_cs_in_xfer_r4: assert property (@(posedge tck) disable iff (tlr)
    !spi_cs_n |-> (st == XFER));

  p_drain_hold_r5: assert property (@(posedge tck) disable iff (tlr)
    (st == DRAIN && active) |=> (st == DRAIN && spi_cs_n));

  p_no_underflow_r8: assert property (@(posedge tck) disable iff (tlr)
    (st == XFER) |-> (cnt != '0));

  p_abort_r9: assert property (@(posedge tck) disable iff (tlr)
    !active |=> (st == HUNT));

  p_idle_unsel_r10: assert property (@(posedge tck) disable iff (tlr)
    !sel |-> (spi_cs_n && !spi_sclk));

endmodule

// File: tb/test_jtag_spi_bridge.sv
`timescale 1ns/1ps
module test_jtag_spi_bridge;
  logic tck = 1'b0;
  logic tlr = 1'b1;
  logic sel = 1'b0;
  logic shift = 1'b0;
  logic tdi = 1'b0;
  logic tdo, spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  always #4 tck = ~tck;

  jtag_spi_bridge i_jtag_spi_bridge (
    .tck(tck), .tlr(tlr), .sel(sel), .shift(shift), .tdi(tdi), .tdo(tdo),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [63:0] pat;
  int rise_n = 0;
  int fall_n = 0;
  int cs_bad_rise = 0;
  bit mosi_got [0:63];
  bit s [0:127];
  int got_tdo [0:127];
  int got_cs [0:127];

  assign spi_miso = pat[fall_n[5:0]];

  always @(posedge spi_sclk) begin
    if (rise_n < 64) mosi_got[rise_n] = spi_mosi;
    if (spi_cs_n) cs_bad_rise++;
    rise_n++;
  end
  always @(negedge spi_sclk) fall_n++;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge tck); #1;
    end
  endtask

  function automatic int exp_tdo(input int c, input int p, input int n);
    int j = c - (p + 33);
    if (j >= 0 && j < n) return int'(pat[j]);
    return int'(s[c]);
  endfunction

  // abort_kind: 0 shift drop, 1 select drop, 2 test-logic-reset; cut < 0: none
  task automatic frame(input int p, input int n, input int d, input bit selv,
                       input int cut, input int abort_kind);
    int total = p + 33 + n + d;
    int stop = (cut < 0) ? total : cut;
    int cs_pre = 0, cs_mid = 0, cs_post = 0, tdo_err = 0;
    logic [31:0] lenv = 32'(n);
    pat = {$urandom, $urandom};
    for (int c = 0; c < total; c++) begin
      if (c < p) s[c] = 1'b0;
      else if (c == p) s[c] = 1'b1;
      else if (c <= p + 32) s[c] = lenv[31 - (c - p - 1)];
      else s[c] = 1'($urandom);
    end
    rise_n = 0; fall_n = 0; cs_bad_rise = 0;
    sel = selv;
    for (int c = 0; c < stop; c++) begin
      shift = 1'b1;
      tdi = s[c];
      @(negedge tck); #1;
      got_tdo[c] = int'(tdo);
      got_cs[c] = int'(spi_cs_n);
      if (!spi_cs_n) begin
        if (c < p + 32) cs_pre++;
        else if (c < p + 32 + n) cs_mid++;
        else cs_post++;
      end
    end
    if (cut >= 0) begin
      case (abort_kind)
        0: shift = 1'b0;
        1: sel = 1'b0;
        default: tlr = 1'b1;
      endcase
      #1;
      chk("R9", "cs_n right after abort", int'(spi_cs_n), 1);
      @(negedge tck); #1;
      chk("R9", "sclk pulses before abort", rise_n, cut - (p + 33));
      chk("R9", "cs_n one cycle after abort", int'(spi_cs_n), 1);
      tlr = 1'b0; sel = 1'b1; shift = 1'b0;
      idle(2);
      return;
    end
    shift = 1'b0;
    idle(2);
    if (!selv) begin
      chk("R10", "sclk pulses when deselected", rise_n, 0);
      chk("R10", "cs_n low cycles when deselected", cs_pre + cs_mid + cs_post, 0);
      sel = 1'b1;
      return;
    end
    chk("R1/R2", "cs_n low cycles before count loaded", cs_pre, 0);
    chk(n == 0 ? "R8" : "R3/R4", "sclk pulse count", rise_n, n);
    chk("R4", "cs_n low cycles during transfer", cs_mid, n);
    chk("R4", "sclk rises with cs_n high", cs_bad_rise, 0);
    chk("R5", "cs_n low cycles in drain", cs_post, 0);
    for (int j = 0; j < n && j < 64; j++)
      if (mosi_got[j] != s[p + 33 + j]) tdo_err += 1000;
    for (int c = 0; c < total; c++)
      if (got_tdo[c] != exp_tdo(c, p, n)) tdo_err++;
    chk("R4", "mosi mismatches (x1000)", tdo_err / 1000, 0);
    chk(n == 0 ? "R6" : "R6/R7", "tdo mismatches", tdo_err % 1000, 0);
  endtask

  initial begin
    void'($urandom(32'h5A17));
    idle(2);
    chk("R11", "cs_n in reset", int'(spi_cs_n), 1);
    chk("R11", "sclk in reset", int'(spi_sclk), 0);
    chk("R11", "tdo in reset", int'(tdo), 0);
    tlr = 1'b0; sel = 1'b1;
    idle(2);
    frame(0, 6, 3, 1'b1, -1, 0);
    frame(4, 1, 0, 1'b1, -1, 0);
    frame(3, 0, 4, 1'b1, -1, 0);
    frame(2, 24, 5, 1'b1, -1, 0);
    frame(5, 20, 0, 1'b1, 5 + 33 + 7, 0);
    frame(1, 12, 2, 1'b1, -1, 0);
    frame(2, 20, 0, 1'b1, 2 + 33 + 4, 1);
    frame(0, 20, 0, 1'b1, 0 + 33 + 9, 2);
    frame(3, 9, 3, 1'b0, -1, 0);
    for (int k = 0; k < 30; k++)
      frame(int'($urandom_range(0, 6)), int'($urandom_range(0, 30)),
            int'($urandom_range(0, 5)), 1'b1, -1, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule